// File: doc/BRIEF.md
# Reciprocal Square-Root Seed Unit

This unit produces a first approximation of 1/sqrt(b) for one floating-point operand held in an 82-bit register layout: sign in bit 81, a 17-bit biased exponent (bias 65535) in bits [80:64], and a 64-bit significand with an explicit integer bit in bits [63:0]. Software refinement steps use the seed afterwards. The result is registered, so it appears one clock after issue. An output predicate tells the refinement code whether the seed is usable (1), or whether the register already holds the final IEEE-mandated answer (0).

A single 256-entry table covers both exponent parities. The exponent's low bit selects one half of the table, and seven leading fraction bits select the entry inside that half. The result exponent is the negated, halved unbiased exponent, with a fixed normalisation step. Several operand classes bypass the table: zero, infinity, NaN and negative operands, a not-a-thing tag, and a cleared qualifying predicate. Each of these yields a defined value with the predicate cleared.

Top module: `rsq_seed_unit`

## Requirements
- R1: For a normal positive operand the table index is {exp[0], sig[62:56]}. exp[0]=1 means an even unbiased exponent, and such entries hold round(2048/sqrt(x)) - 1024, where x is the midpoint of the fraction interval. exp[0]=0 uses 2x in place of x. sig[55:0] and any other change of the exponent by 2 leave the table field unchanged.
- R2: When the predicate output is 1, the result significand has bit 63 = 1, the 10-bit table value in bits [62:53] and zero in bits [52:0].
- R3: A normal positive operand gives sign 0 and predicate 1.
- R4: For a normal positive operand with biased exponent e, the result exponent is 65534 - floor((e - 65535)/2).
- R5: With qp_i = 0 the result register keeps its value and the predicate output becomes 0.
- R6: With qp_i = 1 and nat_i = 1 the result is the not-a-thing value (sign 0, exponent 0x1FFFE, significand 0) with predicate 0, whatever the operand.
- R7: An operand with exponent 0 counts as zero. +0 gives +infinity (sign 0, exponent 0x1FFFF, significand 0x8000_0000_0000_0000), -0 gives -infinity, and the predicate is 0.
- R8: +infinity (exponent 0x1FFFF, sig[62:0] = 0) gives +0 (all bits zero) with predicate 0.
- R9: A NaN (exponent 0x1FFFF, sig[62:0] nonzero) of either sign is returned with sig[62] set and predicate 0.
- R10: A negative nonzero non-NaN operand, including -infinity, gives the indefinite quiet NaN (sign 1, exponent 0x1FFFF, significand 0xC000_0000_0000_0000) with predicate 0.
- R11: For every normal positive operand the seed's relative error against the true 1/sqrt(b) is below 2^-8.831.
- R12: Outputs change only at the rising clock edge that samples the inputs. Reset clears the result and the predicate to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| qp_i | input | 1 | Qualifying predicate of the issued operation |
| nat_i | input | 1 | Not-a-thing tag of the operand |
| src_i | input | 82 | Operand |
| res_o | output | 82 | Destination register value |
| pred_o | output | 1 | Seed-valid predicate |

## Verification
The case that is hardest to reach is the accuracy bound at the ends of each fraction interval, because the worst error sits at interval edges and the bound is only a few percent above it. The stimulus therefore sweeps all 256 indices twice, once with the bits below the index all zero and once with them all one. It alternates exponents of both parities so that both table halves, and both signs of the unbiased exponent, are covered. The bench then compares each seed with a real-valued reciprocal square root. Register-hold behaviour under a cleared predicate is reached by issuing a valid seed first and then presenting special operands with qp_i low.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int EXP_W  = 17;
  localparam int SIG_W  = 64;
  localparam int OP_W   = 1 + EXP_W + SIG_W;
  localparam int IDX_W  = 7;
  localparam int FRAC_W = 10;
  localparam int DEPTH  = 2 ** (IDX_W + 1);
  localparam int BIAS   = 2 ** (EXP_W - 1) - 1;
  localparam int QSH    = 2 * (FRAC_W + 1) + IDX_W + 1 + 10;

  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [EXP_W-1:0] EXP_NAT = EXP_MAX - 1'b1;
  localparam logic [SIG_W-1:0] SIG_ONE = {1'b1, {(SIG_W-1){1'b0}}};
  localparam logic [SIG_W-1:0] SIG_IND = {2'b11, {(SIG_W-2){1'b0}}};

  localparam logic [OP_W-1:0] VAL_NAT   = {1'b0, EXP_NAT, {SIG_W{1'b0}}};
  localparam logic [OP_W-1:0] VAL_PINF  = {1'b0, EXP_MAX, SIG_ONE};
  localparam logic [OP_W-1:0] VAL_NINF  = {1'b1, EXP_MAX, SIG_ONE};
  localparam logic [OP_W-1:0] VAL_INDEF = {1'b1, EXP_MAX, SIG_IND};

  typedef enum logic [1:0] {CL_ZERO, CL_NORM, CL_INF, CL_NAN} cls_e;

  function automatic logic [31:0] isqrt64(input logic [63:0] a);
    logic [31:0] r;
    logic [63:0] t;
    r = '0;
    for (int b = 31; b >= 0; b--) begin
      t = 64'(r | (32'd1 << b));
      if (t * t <= a) r = t[31:0];
    end
    return r;
  endfunction

  // entry = round(2^(FRAC_W+1)/sqrt(x_mid)) - 2^FRAC_W; upper half: even unbiased exponent
  function automatic logic [FRAC_W-1:0] rsq_entry(input int idx);
    logic [63:0] n, q, v;
    logic [31:0] s;
    n = 64'(2 ** (IDX_W + 1) + 2 * (idx % (2 ** IDX_W)) + 1);
    if (idx < 2 ** IDX_W) n = n << 1;
    q = (64'd1 << QSH) / n;
    s = isqrt64(q);
    v = (64'(s) + 64'd16) >> 5;
    return FRAC_W'(v - (64'd1 << FRAC_W));
  endfunction
endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
  import rsq_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output cls_e            cls_o,
  output logic            neg_o
);
  logic [EXP_W-1:0] e;
  logic             frac_nz;

  assign e       = op_i[SIG_W +: EXP_W];
  assign frac_nz = |op_i[SIG_W-2:0];
  assign neg_o   = op_i[OP_W-1];

  always_comb begin
    if (e == '0)            cls_o = CL_ZERO;
    else if (e != EXP_MAX)  cls_o = CL_NORM;
    else if (frac_nz)       cls_o = CL_NAN;
    else                    cls_o = CL_INF;
  end
endmodule

// File: rtl/rsq_table.sv
module rsq_table
  import rsq_pkg::*;
(
  input  logic [IDX_W:0]    idx_i,
  output logic [FRAC_W-1:0] val_o
);
  logic [FRAC_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = rsq_entry(i);
  end

  assign val_o = rom[idx_i];
endmodule

// File: rtl/rsq_exp.sv
module rsq_exp
  import rsq_pkg::*;
(
  input  logic [EXP_W-1:0] e_i,
  output logic [EXP_W-1:0] e_o
);
  localparam int IW = EXP_W + 2;
  logic signed [IW-1:0] unb, half, res;

  always_comb begin
    unb  = $signed({2'b00, e_i}) - IW'(BIAS);
    half = unb >>> 1;
    res  = IW'(BIAS - 1) - half;  // -1: seed normalised from (0.5,1) into [1,2)
    e_o  = res[EXP_W-1:0];
  end
endmodule

// File: rtl/rsq_seed_unit.sv
module rsq_seed_unit
  import rsq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            qp_i,
  input  logic            nat_i,
  input  logic [OP_W-1:0] src_i,
  output logic [OP_W-1:0] res_o,
  output logic            pred_o
);
  cls_e              cls;
  logic              neg;
  logic [FRAC_W-1:0] tval;
  logic [EXP_W-1:0]  rexp;
  logic [OP_W-1:0]   nxt_res;
  logic              nxt_pred;

  rsq_classify u_cls (.op_i(src_i), .cls_o(cls), .neg_o(neg));

  rsq_table u_tab (
    .idx_i({src_i[SIG_W], src_i[SIG_W-2 -: IDX_W]}),
    .val_o(tval)
  );

  rsq_exp u_exp (.e_i(src_i[SIG_W +: EXP_W]), .e_o(rexp));

  always_comb begin
    nxt_pred = 1'b0;
    if (nat_i)
      nxt_res = VAL_NAT;
    else if (cls == CL_NAN)
      nxt_res = src_i | (OP_W'(1) << (SIG_W - 2));
    else if (cls == CL_ZERO)
      nxt_res = neg ? VAL_NINF : VAL_PINF;
    else if (neg)
      nxt_res = VAL_INDEF;
    else if (cls == CL_INF)
      nxt_res = '0;
    else begin
      nxt_res  = {1'b0, rexp, 1'b1, tval, {(SIG_W-1-FRAC_W){1'b0}}};
      nxt_pred = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o  <= '0;
      pred_o <= 1'b0;
    end else begin
      pred_o <= qp_i & nxt_pred;
      if (qp_i) res_o <= nxt_res;
    end
  end

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qp_i |=> (res_o == $past(res_o)) && !pred_o);

  p_fmt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_o |-> res_o[SIG_W-1] && (res_o[SIG_W-2-FRAC_W:0] == '0) && !res_o[OP_W-1]);

  p_nat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qp_i && nat_i |=> (res_o == VAL_NAT) && !pred_o);

  p_pzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qp_i && !nat_i && !src_i[OP_W-1] && (src_i[SIG_W +: EXP_W] == '0)
    |=> (res_o == VAL_PINF) && !pred_o);

  p_nan_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qp_i && !nat_i && (src_i[SIG_W +: EXP_W] == EXP_MAX) && (|src_i[SIG_W-2:0])
    |=> res_o[SIG_W-2] && (res_o[OP_W-1:SIG_W] == $past(src_i[OP_W-1:SIG_W])) && !pred_o);

  p_neg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qp_i && !nat_i && src_i[OP_W-1] && (src_i[SIG_W +: EXP_W] != '0) && !(|src_i[SIG_W-2:0])
    |=> (res_o == VAL_INDEF) && !pred_o);
endmodule

// File: tb/rsq_seed_unit_test.sv
`timescale 1ns/1ps
module rsq_seed_unit_test;
  localparam int NV = 15;
  localparam real TOL = 0.0021955;  // 2^-8.831

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        qp_i = 1'b0;
  logic        nat_i = 1'b0;
  logic [81:0] src_i = '0;
  logic [81:0] res_o;
  logic        pred_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  rsq_seed_unit uut (.*);

  // {qp, nat, operand, expected result, expected predicate}
  localparam logic [166:0] VECS [NV] = '{
    {2'b10, {1'b0,17'h00000,64'h0}, {1'b0,17'h1FFFF,64'h8000_0000_0000_0000}, 1'b0},            // R7 +0
    {2'b10, {1'b1,17'h00000,64'h0}, {1'b1,17'h1FFFF,64'h8000_0000_0000_0000}, 1'b0},            // R7 -0
    {2'b10, {1'b0,17'h00000,64'h0000_0000_0000_1234}, {1'b0,17'h1FFFF,64'h8000_0000_0000_0000}, 1'b0}, // R7 zero exp
    {2'b10, {1'b0,17'h1FFFF,64'h8000_0000_0000_0000}, 82'h0, 1'b0},                            // R8 +inf
    {2'b10, {1'b1,17'h1FFFF,64'h8000_0000_0000_0000}, {1'b1,17'h1FFFF,64'hC000_0000_0000_0000}, 1'b0}, // R10 -inf
    {2'b10, {1'b1,17'h0FFFF,64'h8000_0000_0000_0000}, {1'b1,17'h1FFFF,64'hC000_0000_0000_0000}, 1'b0}, // R10 -1.0
    {2'b10, {1'b0,17'h1FFFF,64'h8000_0000_0000_0001}, {1'b0,17'h1FFFF,64'hC000_0000_0000_0001}, 1'b0}, // R9 snan
    {2'b10, {1'b1,17'h1FFFF,64'hC123_0000_0000_0000}, {1'b1,17'h1FFFF,64'hC123_0000_0000_0000}, 1'b0}, // R9 neg qnan
    {2'b11, {1'b0,17'h0FFFF,64'h8000_0000_0000_0000}, {1'b0,17'h1FFFE,64'h0}, 1'b0},            // R6 normal
    {2'b11, {1'b1,17'h1FFFF,64'hC000_0000_0000_0001}, {1'b0,17'h1FFFE,64'h0}, 1'b0},            // R6 nan
    {2'b10, {1'b0,17'h0FFFF,64'h8000_0000_0000_0000}, {1'b0,17'h0FFFE,64'hFF80_0000_0000_0000}, 1'b1}, // R1 R4 1.0
    {2'b10, {1'b0,17'h10001,64'h8000_0000_0000_0000}, {1'b0,17'h0FFFD,64'hFF80_0000_0000_0000}, 1'b1}, // R1 R4 4.0
    {2'b10, {1'b0,17'h10000,64'h8000_0000_0000_0000}, {1'b0,17'h0FFFE,64'hB4A0_0000_0000_0000}, 1'b1}, // R1 R4 2.0
    {2'b10, {1'b0,17'h0FFFE,64'h8000_0000_0000_0000}, {1'b0,17'h0FFFF,64'hB4A0_0000_0000_0000}, 1'b1}, // R1 R4 0.5
    {2'b10, {1'b0,17'h0FFFF,64'h80FF_FFFF_FFFF_FFFF}, {1'b0,17'h0FFFE,64'hFF80_0000_0000_0000}, 1'b1}  // R1 low bits
  };
  localparam int VREQ [NV] = '{7,7,7,8,10,10,9,9,6,6,1,4,1,4,1};

  task automatic chk(input string tag, input logic [82:0] got, input logic [82:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic qp, input logic nat, input logic [81:0] op);
    qp_i = qp; nat_i = nat; src_i = op;
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [81:0] held;
    logic [9:0]  t_lo;
    repeat (3) @(negedge clk_i);
    chk("R12 reset", {pred_o, res_o}, 83'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      logic [166:0] v;
      v = VECS[i];
      issue(v[166], v[165], v[164:83]);
      chk($sformatf("R%0d vector %0d", VREQ[i], i), {pred_o, res_o}, {v[0], v[82:1]});
    end

    // R5: cleared qualifying predicate holds the register
    issue(1'b1, 1'b0, {1'b0,17'h10000,64'h8000_0000_0000_0000});
    held = res_o;
    issue(1'b0, 1'b0, 82'h0);
    chk("R5 hold zero op", {pred_o, res_o}, {1'b0, held});
    issue(1'b0, 1'b1, {1'b1,17'h1FFFF,64'hC000_0000_0000_0001});
    chk("R5 hold nat op", {pred_o, res_o}, {1'b0, held});

    // R12: no change before the edge
    qp_i = 1'b1; nat_i = 1'b0; src_i = 82'h0;
    #5;
    chk("R12 before edge", {pred_o, res_o}, {1'b0, held});
    @(negedge clk_i);
    chk("R12 after edge", {pred_o, res_o}, {1'b0, 1'b0, 17'h1FFFF, 64'h8000_0000_0000_0000});

    // R1 R2 R3 R4 R11 sweep over every index, both interval ends
    for (int idx = 0; idx < 256; idx++) begin
      for (int hi = 0; hi < 2; hi++) begin
        logic [16:0] e;
        logic [63:0] sg;
        int u, k;
        real m, rm, prod, err;
        e  = (idx >= 128) ? 17'(32'h0FFFF + 2 * (idx % 7) - 6) : 17'(32'h10000 + 2 * (idx % 9) - 8);
        sg = {1'b1, 7'(idx), hi ? 56'hFF_FFFF_FFFF_FFFF : 56'h0};
        issue(1'b1, 1'b0, {1'b0, e, sg});
        u = int'(e) - 65535;
        chk($sformatf("R3 sign/pred idx %0d", idx), {pred_o, res_o[81]}, 83'({1'b1, 1'b0}));
        chk($sformatf("R2 fmt idx %0d", idx), {res_o[63], res_o[52:0]}, 83'({1'b1, 53'h0}));
        chk($sformatf("R4 exp idx %0d", idx), 83'(res_o[80:64]), 83'(65534 - (u >>> 1)));
        if (hi == 0) t_lo = res_o[62:53];
        else chk($sformatf("R1 low bits idx %0d", idx), 83'(res_o[62:53]), 83'(t_lo));
        m    = real'(sg[63:40]) / 8388608.0;
        rm   = real'(res_o[63:53]) / 1024.0;
        k    = (int'(res_o[80:64]) - 65535) + (u >>> 1);
        prod = rm * $sqrt(m) * (e[0] ? 1.0 : $sqrt(2.0)) * (2.0 ** k);
        err  = (prod > 1.0) ? prod - 1.0 : 1.0 - prod;
        n_cmp++;
        if (err >= TOL) begin
          n_bad++;
          $display("FAIL R11 idx %0d: got error %f expected below %f", idx, err, TOL);
        end
      end
    end

    // R1: exponent change by two keeps the table field
    issue(1'b1, 1'b0, {1'b0,17'h12345,64'hA500_0000_0000_0000});
    t_lo = res_o[62:53];
    issue(1'b1, 1'b0, {1'b0,17'h12347,64'hA5FF_0000_0000_0000});
    chk("R1 parity reuse", 83'(res_o[62:53]), 83'(t_lo));

    // R12: reset mid-run
    rst_ni = 1'b0;
    #3;
    chk("R12 async reset", {pred_o, res_o}, 83'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    summary();
    $finish;
  end
endmodule